// File: doc/BRIEF.md
# Parallel-Port Printer-Side Byte Receiver

This block plays the printer end of a classic byte-wide parallel printer link. The host drives eight data lines and an active-low strobe, plus three control lines: an active-low reset request, an active-low line-feed hint and an active-low select. The block times the strobe pulse and latches the byte when strobe returns high. It then offers the byte, tagged with the line-feed hint, on a valid/ready stream. When downstream takes the byte, the block answers the host with a timed low acknowledge pulse and then drops busy.

Three fault inputs drive the returned status lines with the link's usual polarities: paper out, offline and a general fault. Busy, active-low error, paper-end and selected-status are all derived from them. A strobe that arrives while busy is showing drops its byte and sets a sticky overrun flag. A long low pulse on the host's reset line clears the pending byte, any acknowledge in progress and the overrun flag. Every pulse width is a clock-cycle count set by a parameter.

Top module: `lpt_byte_receiver`

## Requirements
- R1: A strobe low for at least STB_MIN_CYC clock cycles, while selected and not busy, latches the data lines and the line-feed hint (m_feed = 1 when autofeed_n was 0). m_valid rises on the third rising clock edge after strobe_n returns high and is still 0 after the second.
- R2: A strobe low for fewer than STB_MIN_CYC cycles is ignored: m_valid, busy and overrun do not change.
- R3: Busy rises in the same cycle that m_valid rises. While m_valid is high and m_ready is low, m_valid stays high and m_data stays stable.
- R4: The cycle after m_valid and m_ready are both high, m_valid is low and ack_n is low. ack_n then stays low for exactly ACK_CYC cycles.
- R5: The receiver's busy stays high for one cycle after ack_n returns high, then falls.
- R6: busy is high whenever paper_out, offline or fault_err is high, and also while a byte is pending or being acknowledged.
- R7: paper_end follows paper_out.
- R8: select_in is high when select_n has been low for at least two cycles and offline is low; otherwise it is low.
- R9: error_n is low whenever paper_out, offline or fault_err is high, and high otherwise.
- R10: A qualifying strobe while busy is high does not replace the pending byte and sets overrun, which stays set until reset or a long host reset pulse.
- R11: init_n held low for more than INIT_MIN_CYC cycles clears m_valid, ack_n (to 1), busy and overrun. A pulse of exactly INIT_MIN_CYC cycles has no effect.
- R12: A qualifying strobe while select_n is high is ignored and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Host byte strobe, active low, asynchronous |
| pdata | input | 8 | Host data lines |
| init_n | input | 1 | Host reset request, active low, asynchronous |
| autofeed_n | input | 1 | Host line-feed hint, active low |
| select_n | input | 1 | Host select, active low, asynchronous |
| paper_out | input | 1 | Fault: no paper |
| offline | input | 1 | Fault: receiver offline |
| fault_err | input | 1 | Fault: general error |
| busy | output | 1 | Busy to host, active high |
| ack_n | output | 1 | Acknowledge to host, active low pulse |
| paper_end | output | 1 | Paper-end status, active high |
| select_in | output | 1 | Selected status, active high |
| error_n | output | 1 | Error status, active low |
| m_valid | output | 1 | Stream byte valid |
| m_data | output | 8 | Stream byte |
| m_feed | output | 1 | Line-feed hint captured with the byte |
| m_ready | input | 1 | Stream accept from downstream |
| overrun | output | 1 | Sticky: strobe arrived while busy |

## Verification
The bench builds the block with STB_MIN_CYC = 4, ACK_CYC = 6 and INIT_MIN_CYC = 10. These values put every threshold within a few cycles. Random strobe lengths from two cycles below to three above the limit land on both sides of the qualification boundary. Host reset pulses of exactly the limit and of the limit plus three test the "longer than" rule. Acknowledge length is counted cycle by cycle, and the short window keeps the random transaction loop fast.

// File: rtl/lpt_rx_pkg.sv
package lpt_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HOLD = 2'd1,
        RX_ACK  = 2'd2,
        RX_TAIL = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic       feed;
        logic [7:0] data;
    } rx_byte_t;

    typedef struct packed {
        logic paper_out;
        logic offline;
        logic general;
    } fault_t;

    function automatic logic any_fault(input fault_t f);
        return f.paper_out | f.offline | f.general;
    endfunction

    function automatic rx_byte_t make_byte(input logic [8:0] raw);
        rx_byte_t b;
        b.feed = ~raw[8];
        b.data = raw[7:0];
        return b;
    endfunction

endpackage

// File: rtl/lpt_sync_bank.sv
module lpt_sync_bank #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lpt_low_meter.sv
module lpt_low_meter #(
    parameter int MIN_CYC   = 4,
    parameter bit HOLD_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_n,
    output logic hit
);
    localparam int             CW      = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0]  CNT_TOP = CW'(MIN_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!lvl_n) begin
            if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    generate
        if (HOLD_MODE) begin : g_hold
            assign hit = !lvl_n && (cnt == CNT_TOP);
        end else begin : g_rise
            logic was_low;
            always_ff @(posedge clk) begin
                if (rst) was_low <= 1'b0;
                else     was_low <= !lvl_n;
            end
            assign hit = was_low && lvl_n && (cnt == CNT_TOP);
        end
    endgenerate
endmodule

// File: rtl/lpt_rx_fsm.sv
module lpt_rx_fsm
    import lpt_rx_pkg::*;
#(
    parameter int ACK_CYC = 250
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     take,
    input  rx_byte_t cap,
    input  logic     m_ready,
    output logic     m_valid,
    output rx_byte_t m_byte,
    output logic     rx_busy,
    output logic     ack_n
);
    localparam int            AW       = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;
    localparam logic [AW-1:0] ACK_LAST = AW'(ACK_CYC - 1);

    rx_state_e     state;
    logic [AW-1:0] ack_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state   <= RX_IDLE;
            ack_cnt <= '0;
        end else begin
            case (state)
                RX_IDLE: if (take) state <= RX_HOLD;
                RX_HOLD: if (m_ready) begin
                    state   <= RX_ACK;
                    ack_cnt <= ACK_LAST;
                end
                RX_ACK: begin
                    if (ack_cnt == '0) state <= RX_TAIL;
                    else               ack_cnt <= ack_cnt - 1'b1;
                end
                RX_TAIL: state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                            m_byte <= '0;
        else if (state == RX_IDLE && take)  m_byte <= cap;
    end

    assign m_valid = (state == RX_HOLD);
    assign rx_busy = (state != RX_IDLE);
    assign ack_n   = (state != RX_ACK);
endmodule

// File: rtl/lpt_status.sv
module lpt_status
    import lpt_rx_pkg::*;
(
    input  fault_t flt,
    input  logic   sel_low,
    input  logic   rx_busy,
    output logic   busy,
    output logic   error_n,
    output logic   paper_end,
    output logic   select_in
);
    always_comb begin
        busy      = rx_busy | any_fault(flt);
        error_n   = ~any_fault(flt);
        paper_end = flt.paper_out;
        select_in = sel_low & ~flt.offline;
    end
endmodule

// File: rtl/lpt_byte_receiver.sv
module lpt_byte_receiver
    import lpt_rx_pkg::*;
#(
    parameter int STB_MIN_CYC  = 25,
    parameter int ACK_CYC      = 250,
    parameter int INIT_MIN_CYC = 2500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_n,
    input  logic [7:0] pdata,
    input  logic       init_n,
    input  logic       autofeed_n,
    input  logic       select_n,
    input  logic       paper_out,
    input  logic       offline,
    input  logic       fault_err,
    output logic       busy,
    output logic       ack_n,
    output logic       paper_end,
    output logic       select_in,
    output logic       error_n,
    output logic       m_valid,
    output logic [7:0] m_data,
    output logic       m_feed,
    input  logic       m_ready,
    output logic       overrun
);
    localparam int CTRL_W = 3;
    localparam int DATA_W = 9;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] data_q;
    logic              stb_ok;
    logic              init_hold;
    logic              take_ok;
    logic              take;
    logic              rx_busy;
    rx_byte_t          held;
    fault_t            flt;

    lpt_sync_bank #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ctrl_sync (
        .clk(clk), .rst(rst),
        .d({select_n, init_n, strobe_n}),
        .q(ctrl_q)
    );

    lpt_sync_bank #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL(9'h100)) u_data_sync (
        .clk(clk), .rst(rst),
        .d({autofeed_n, pdata}),
        .q(data_q)
    );

    lpt_low_meter #(.MIN_CYC(STB_MIN_CYC), .HOLD_MODE(1'b0)) u_stb_meter (
        .clk(clk), .rst(rst), .lvl_n(ctrl_q[0]), .hit(stb_ok)
    );

    lpt_low_meter #(.MIN_CYC(INIT_MIN_CYC), .HOLD_MODE(1'b1)) u_init_meter (
        .clk(clk), .rst(rst), .lvl_n(ctrl_q[1]), .hit(init_hold)
    );

    assign flt = '{paper_out: paper_out, offline: offline, general: fault_err};

    assign take_ok = stb_ok && !init_hold && !ctrl_q[2];
    assign take    = take_ok && !busy;

    lpt_rx_fsm #(.ACK_CYC(ACK_CYC)) u_fsm (
        .clk(clk), .rst(rst), .clear(init_hold),
        .take(take), .cap(make_byte(data_q)),
        .m_ready(m_ready), .m_valid(m_valid), .m_byte(held),
        .rx_busy(rx_busy), .ack_n(ack_n)
    );

    lpt_status u_status (
        .flt(flt), .sel_low(!ctrl_q[2]), .rx_busy(rx_busy),
        .busy(busy), .error_n(error_n),
        .paper_end(paper_end), .select_in(select_in)
    );

    always_ff @(posedge clk) begin
        if (rst || init_hold)    overrun <= 1'b0;
        else if (take_ok && busy) overrun <= 1'b1;
    end

    assign m_data = held.data;
    assign m_feed = held.feed;
endmodule

// File: rtl/lpt_rx_chk.sv
module lpt_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       rx_busy,
    input logic       ack_n,
    input logic       m_valid,
    input logic       m_ready,
    input logic [7:0] m_data,
    input logic       overrun,
    input logic       init_hold,
    input logic       paper_out,
    input logic       offline,
    input logic       fault_err,
    input logic       paper_end,
    input logic       error_n
);
    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready && !init_hold) |=> (m_valid && $stable(m_data)));

    // R4
    ack_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && !init_hold) |=> (!ack_n && !m_valid));

    // R4
    no_valid_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> !m_valid);

    // R5
    busy_outlasts_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rx_busy) && !$past(init_hold)) |-> $past(ack_n));

    // R6
    busy_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (paper_out || offline || fault_err || !ack_n) |-> busy);

    // R9
    err_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (paper_out || offline || fault_err) |-> !error_n);

    // R7
    paper_line_chk: assert property (@(posedge clk) disable iff (rst)
        paper_out |-> paper_end);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !init_hold) |=> overrun);
endmodule

bind lpt_byte_receiver lpt_rx_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .rx_busy(rx_busy), .ack_n(ack_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .overrun(overrun), .init_hold(init_hold),
    .paper_out(paper_out), .offline(offline), .fault_err(fault_err),
    .paper_end(paper_end), .error_n(error_n)
);

// File: tb/lpt_byte_receiver_test.sv
`timescale 1ns/1ps
module lpt_byte_receiver_test;
    localparam int STB_MIN  = 4;
    localparam int ACK_CYC  = 6;
    localparam int INIT_MIN = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_n = 1'b1, init_n = 1'b1, autofeed_n = 1'b1, select_n = 1'b0;
    logic [7:0] pdata = '0;
    logic       paper_out = 1'b0, offline = 1'b0, fault_err = 1'b0, m_ready = 1'b0;
    logic       busy, ack_n, paper_end, select_in, error_n, m_valid, m_feed, overrun;
    logic [7:0] m_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lpt_byte_receiver #(.STB_MIN_CYC(STB_MIN), .ACK_CYC(ACK_CYC),
                        .INIT_MIN_CYC(INIT_MIN)) uut (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .pdata(pdata),
        .init_n(init_n), .autofeed_n(autofeed_n), .select_n(select_n),
        .paper_out(paper_out), .offline(offline), .fault_err(fault_err),
        .busy(busy), .ack_n(ack_n), .paper_end(paper_end),
        .select_in(select_in), .error_n(error_n), .m_valid(m_valid),
        .m_data(m_data), .m_feed(m_feed), .m_ready(m_ready), .overrun(overrun)
    );

    function automatic bit qualifies(input int len);
        return len >= STB_MIN;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic f, input int len, input bit idle_chk);
        @(negedge clk);
        pdata = b; autofeed_n = ~f; strobe_n = 1'b0;
        repeat (len) @(negedge clk);
        strobe_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        if (idle_chk) chk("R1 m_valid not yet up", m_valid, 0);
        @(posedge clk); @(negedge clk);
        autofeed_n = 1'b1;
    endtask

    task automatic host_init(input int len);
        @(negedge clk); init_n = 1'b0;
        repeat (len) @(negedge clk);
        init_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic accept(input int delay, input logic [7:0] exp_b);
        int n;
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk("R3 still valid", m_valid, 1);
            chk("R3 data stable", m_data, exp_b);
        end
        @(negedge clk); m_ready = 1'b1;
        @(negedge clk); m_ready = 1'b0;
        chk("R4 valid dropped", m_valid, 0);
        n = 0;
        while (ack_n == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R4 ack low cycles", n, ACK_CYC);
        chk("R5 busy one cycle past ack", busy, 1);
        @(negedge clk);
        chk("R5 busy released", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic       f;
        int         len, dly;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 reset busy", busy, 0);
        chk("R4 reset ack_n", ack_n, 1);
        chk("R1 reset m_valid", m_valid, 0);
        chk("R10 reset overrun", overrun, 0);
        chk("R9 reset error_n", error_n, 1);
        chk("R8 reset select_in", select_in, 1);

        // R1 R3: minimum qualifying strobe
        send(8'hA5, 1'b1, STB_MIN, 1'b1);
        chk("R1 m_valid", m_valid, 1);
        chk("R1 m_data", m_data, 8'hA5);
        chk("R1 m_feed", m_feed, 1);
        chk("R3 busy with valid", busy, 1);
        accept(2, 8'hA5);

        // R2: one cycle short
        send(8'h5A, 1'b0, STB_MIN - 1, 1'b1);
        chk("R2 short ignored valid", m_valid, 0);
        chk("R2 short busy", busy, 0);
        chk("R2 short overrun", overrun, 0);

        // R6 R7 R8 R9: fault status
        @(negedge clk); paper_out = 1'b1; @(negedge clk);
        chk("R7 paper_end", paper_end, 1);
        chk("R6 busy paper", busy, 1);
        chk("R9 error_n paper", error_n, 0);
        chk("R8 select_in paper", select_in, 1);
        paper_out = 1'b0; offline = 1'b1; @(negedge clk);
        chk("R8 select_in offline", select_in, 0);
        chk("R9 error_n offline", error_n, 0);
        chk("R6 busy offline", busy, 1);
        chk("R7 paper_end clear", paper_end, 0);
        offline = 1'b0; fault_err = 1'b1; @(negedge clk);
        chk("R9 error_n fault", error_n, 0);
        chk("R6 busy fault", busy, 1);
        fault_err = 1'b0; @(negedge clk);
        chk("R6 busy clear", busy, 0);
        chk("R9 error_n clear", error_n, 1);

        // R10: strobe while offline
        offline = 1'b1;
        send(8'h11, 1'b0, STB_MIN + 1, 1'b1);
        chk("R10 offline no capture", m_valid, 0);
        chk("R10 offline overrun", overrun, 1);
        offline = 1'b0;
        host_init(INIT_MIN + 3);
        chk("R11 overrun cleared", overrun, 0);

        // R10 R11: strobe over a pending byte, then host reset
        send(8'h3C, 1'b0, STB_MIN + 2, 1'b1);
        chk("R1 second capture", m_data, 8'h3C);
        chk("R1 feed low", m_feed, 0);
        send(8'h81, 1'b1, STB_MIN, 1'b0);
        chk("R10 pending kept", m_valid, 1);
        chk("R10 pending data", m_data, 8'h3C);
        chk("R10 overrun set", overrun, 1);
        host_init(INIT_MIN);
        chk("R11 exact-length init no effect valid", m_valid, 1);
        chk("R11 exact-length init no effect overrun", overrun, 1);
        host_init(INIT_MIN + 3);
        chk("R11 valid cleared", m_valid, 0);
        chk("R11 busy cleared", busy, 0);
        chk("R11 overrun cleared", overrun, 0);
        chk("R11 ack_n high", ack_n, 1);

        // R12: deselected
        @(negedge clk); select_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 deselected", select_in, 0);
        send(8'h77, 1'b0, STB_MIN + 1, 1'b1);
        chk("R12 no capture", m_valid, 0);
        chk("R12 no overrun", overrun, 0);
        select_n = 1'b0;
        repeat (4) @(negedge clk);

        // random lengths around the threshold
        for (int it = 0; it < 40; it++) begin
            b   = 8'($urandom);
            f   = 1'($urandom);
            len = STB_MIN - 2 + int'($urandom_range(0, 5));
            dly = int'($urandom_range(0, 3));
            send(b, f, len, 1'b1);
            if (qualifies(len)) begin
                chk("R1 rnd valid", m_valid, 1);
                chk("R1 rnd data", m_data, b);
                chk("R1 rnd feed", m_feed, f);
                accept(dly, b);
            end else begin
                chk("R2 rnd ignored", m_valid, 0);
                chk("R2 rnd busy", busy, 0);
            end
            chk("R10 rnd overrun", overrun, 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule